// File: doc/BRIEF.md
# Virtually Tagged Two-Way Data Cache

This block is a write-back data cache that finds its set and its tag in the virtual address. It does not wait for the physical address. When a request is accepted, a translation request for the same address leaves on a separate port in that same cycle. A hit is answered from the arrays while translation is still running. Only a miss uses the translated address: the line is refilled from it, and the physical line address is kept beside the line for a later write-back.

Two processes can use the same virtual address for different data. To keep them apart, every line also holds the identifier of the process that filled it. A lookup hits only when the line is valid, the virtual tag is equal and the stored identifier equals the identifier given with the request. A second defence is a whole-cache flush, for example at a context switch. The flush first writes every dirty line back to its stored physical address, then invalidates every line.

The cache has 128 sets of two ways each and 32-byte lines, which gives 8 KB. Addresses are 32 bits and process identifiers are 8 bits. One request is in flight at a time. Memory moves whole lines, one line per handshake.

Top module: `vtc_cache`

## Requirements
- R1: Each request address is split into three fields. Bits [4:2] select the 32-bit word in the line. Bits [11:5] select the set. Bits [31:12] form the virtual tag. Addresses in the same set with different tags occupy the two ways at the same time.
- R2: In the cycle a request is accepted (`req_valid && req_ready`), `xl_req_valid` is high and `xl_req_vaddr` and `xl_req_pid` carry that request's address and identifier.
- R3: A hit raises `resp_valid` in the cycle after acceptance, whatever the translation latency. A read returns the addressed word. A write returns the written data.
- R4: A hit requires valid, an equal virtual tag and an equal process identifier. The same virtual address under another identifier misses and returns that process's own memory data.
- R5: A miss waits for `xl_resp_valid`. It then refills from line address `xl_resp_paddr[31:5]` and keeps that line address with the line.
- R6: Before the refill, a dirty victim is written back to the physical line address stored with that victim, not to the new one.
- R7: A store hit replaces the word and marks the line dirty. A store miss allocates the line, then merges the word into it.
- R8: The victim is an invalid way if the set has one. Otherwise it is the least recently used way, tracked by one bit per set that is updated on every hit and every fill.
- R9: A one-cycle `flush_req`, taken while the cache is idle, writes back every dirty line, invalidates every line and then pulses `flush_done` high for exactly one cycle.
- R10: A change of `req_pid` invalidates nothing. Lines of earlier identifiers still hit when those identifiers return.
- R11: Only one request is in flight at a time. `req_ready` stays low until the previous response has been given and the previous translation response has arrived.
- R12: After reset `req_ready` is high and `resp_valid`, `mem_req_valid` and `flush_done` are low.
- R13: Once raised, a memory request keeps its valid, direction and address unchanged until `mem_resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load/store request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_pid | input | 8 | Current process identifier |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Load data, or store data echoed |
| xl_req_valid | output | 1 | Translation request strobe |
| xl_req_vaddr | output | 32 | Address to translate |
| xl_req_pid | output | 8 | Identifier for translation |
| xl_resp_valid | input | 1 | Translation result strobe |
| xl_resp_paddr | input | 32 | Translated physical address |
| mem_req_valid | output | 1 | Memory line request, held until answered |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 27 | Physical line address |
| mem_req_wline | output | 256 | Line data for write-back |
| mem_resp_valid | input | 1 | Memory completes the request |
| mem_resp_rline | input | 256 | Line data for a read |
| flush_req | input | 1 | Request a full write-back and invalidate |
| flush_done | output | 1 | One-cycle strobe when the flush ends |

## Verification
On every cycle the assertions check the protocol side of the block. They cover the translation request going out in the acceptance cycle, at most one translation and one request in flight, no response without an accepted request, memory requests held until answered, and `flush_done` lasting a single cycle. Everything that depends on stored contents can only be shown by the bench scenarios. That includes hit versus miss under each identifier, the least-recently-used victim choice, write-back of a victim to its own stored physical line, store allocation and the invalidation done by a flush. The bench shows these through response latency, returned data and the final memory image compared with a model of the architectural state.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int OFF_W   = 5;
    localparam int IDX_W   = 7;
    localparam int WAYS    = 2;
    localparam int PID_W   = 8;
    localparam int WORD_W  = 32;

    localparam int SETS    = 1 << IDX_W;
    localparam int VTAG_W  = VA_W - IDX_W - OFF_W;
    localparam int PLINE_W = PA_W - OFF_W;
    localparam int WSEL_W  = OFF_W - $clog2(WORD_W / 8);
    localparam int WORDS   = 1 << WSEL_W;
    localparam int LINE_W  = WORDS * WORD_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LINES   = SETS * WAYS;
    localparam int LN_W    = IDX_W + WAY_W;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic [VTAG_W-1:0]  vtag;
        logic [PID_W-1:0]   pid;
        logic [PLINE_W-1:0] pline;
    } meta_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_XL, ST_WB, ST_FILL, ST_FL_SCAN, ST_FL_WB
    } state_t;

    typedef struct packed {
        state_t             st;
        logic [VA_W-1:0]    va;
        logic [WORD_W-1:0]  wdata;
        logic               wr;
        logic [PID_W-1:0]   pid;
        logic [PLINE_W-1:0] pline;
        logic               xl_have;
        logic               xl_pend;
        logic [WAY_W-1:0]   vway;
        logic               rvalid;
        logic [WORD_W-1:0]  rdata;
        logic [LN_W-1:0]    fptr;
        logic               fdone;
    } ctl_t;

    function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [VTAG_W-1:0] vtag_of(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: VTAG_W];
    endfunction

    function automatic logic [WSEL_W-1:0] wsel_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1 -: WSEL_W];
    endfunction

    function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s);
        return l[s*WORD_W +: WORD_W];
    endfunction

    function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                   input logic [WSEL_W-1:0] s,
                                                   input logic [WORD_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = l;
        r[s*WORD_W +: WORD_W] = w;
        return r;
    endfunction
endpackage

// File: rtl/vtc_line_store.sv
module vtc_line_store
    import vtc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_set,
    output meta_t [WAYS-1:0]              rd_meta,
    output logic  [WAYS-1:0][LINE_W-1:0]  rd_line,
    output logic                          rd_lru,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  meta_t                         wr_meta,
    input  logic [LINE_W-1:0]             wr_line,
    input  logic                          lru_we,
    input  logic [IDX_W-1:0]              lru_set,
    input  logic                          lru_val
);
    logic lru_q [SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        meta_t             meta_q [SETS];
        logic [LINE_W-1:0] data_q [SETS];
        logic              sel;

        assign sel = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) meta_q[s] <= '0;
            end else if (sel) begin
                meta_q[wr_set] <= wr_meta;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) data_q[wr_set] <= wr_line;
        end

        assign rd_meta[w] = meta_q[rd_set];
        assign rd_line[w] = data_q[rd_set];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
        end else if (lru_we) begin
            lru_q[lru_set] <= lru_val;
        end
    end

    assign rd_lru = lru_q[rd_set];
endmodule

// File: rtl/vtc_tag_match.sv
module vtc_tag_match
    import vtc_pkg::*;
(
    input  meta_t [WAYS-1:0]   metas,
    input  logic [VTAG_W-1:0]  vtag,
    input  logic [PID_W-1:0]   pid,
    output logic               hit,
    output logic [WAY_W-1:0]   hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = metas[w].valid && (metas[w].vtag == vtag) && (metas[w].pid == pid);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/vtc_victim.sv
module vtc_victim
    import vtc_pkg::*;
(
    input  meta_t [WAYS-1:0]  metas,
    input  logic              lru,
    output logic [WAY_W-1:0]  way
);
    always_comb begin
        way = WAY_W'(lru);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!metas[w].valid) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/vtc_cache.sv
module vtc_cache
    import vtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [PID_W-1:0]   req_pid,
    output logic               resp_valid,
    output logic [WORD_W-1:0]  resp_rdata,
    output logic               xl_req_valid,
    output logic [VA_W-1:0]    xl_req_vaddr,
    output logic [PID_W-1:0]   xl_req_pid,
    input  logic               xl_resp_valid,
    input  logic [PA_W-1:0]    xl_resp_paddr,
    output logic               mem_req_valid,
    output logic               mem_req_write,
    output logic [PLINE_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0]  mem_req_wline,
    input  logic               mem_resp_valid,
    input  logic [LINE_W-1:0]  mem_resp_rline,
    input  logic               flush_req,
    output logic               flush_done
);
    ctl_t q, d;

    logic [IDX_W-1:0]             rd_set;
    meta_t [WAYS-1:0]             rd_meta;
    logic  [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                         rd_lru;
    logic                         wr_en;
    logic [IDX_W-1:0]             wr_set;
    logic [WAY_W-1:0]             wr_way;
    meta_t                        wr_meta;
    logic [LINE_W-1:0]            wr_line;
    logic                         lru_we;
    logic [IDX_W-1:0]             lru_set;
    logic                         lru_val;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             vic_way;
    logic                         idle_free;
    logic                         accept;
    logic [IDX_W-1:0]             fset;
    logic [WAY_W-1:0]             fway;
    meta_t                        fmeta;
    meta_t                        vmeta;
    meta_t                        hmeta;

    vtc_line_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (rd_set),
        .rd_meta (rd_meta),
        .rd_line (rd_line),
        .rd_lru  (rd_lru),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_way  (wr_way),
        .wr_meta (wr_meta),
        .wr_line (wr_line),
        .lru_we  (lru_we),
        .lru_set (lru_set),
        .lru_val (lru_val)
    );

    vtc_tag_match u_match (
        .metas   (rd_meta),
        .vtag    (vtag_of(req_vaddr)),
        .pid     (req_pid),
        .hit     (hit),
        .hit_way (hit_way)
    );

    vtc_victim u_victim (
        .metas (rd_meta),
        .lru   (rd_lru),
        .way   (vic_way)
    );

    assign fset  = q.fptr[LN_W-1:WAY_W];
    assign fway  = q.fptr[WAY_W-1:0];
    assign fmeta = rd_meta[fway];
    assign vmeta = rd_meta[q.vway];
    assign hmeta = rd_meta[hit_way];

    assign idle_free    = (q.st == ST_IDLE) && !q.xl_pend;
    assign req_ready    = idle_free && !flush_req;
    assign accept       = req_ready && req_valid;
    assign xl_req_valid = accept;
    assign xl_req_vaddr = req_vaddr;
    assign xl_req_pid   = req_pid;
    assign resp_valid   = q.rvalid;
    assign resp_rdata   = q.rdata;
    assign flush_done   = q.fdone;

    always_comb begin
        d          = q;
        d.rvalid   = 1'b0;
        d.fdone    = 1'b0;

        rd_set        = idx_of(q.va);
        wr_en         = 1'b0;
        wr_set        = idx_of(q.va);
        wr_way        = q.vway;
        wr_meta       = vmeta;
        wr_line       = rd_line[q.vway];
        lru_we        = 1'b0;
        lru_set       = idx_of(q.va);
        lru_val       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = q.pline;
        mem_req_wline = rd_line[q.vway];

        unique case (q.st)
            ST_IDLE: begin
                rd_set = idx_of(req_vaddr);
                if (q.xl_pend && xl_resp_valid) d.xl_pend = 1'b0;
                if (idle_free && flush_req) begin
                    d.st   = ST_FL_SCAN;
                    d.fptr = '0;
                end else if (accept) begin
                    d.va      = req_vaddr;
                    d.wdata   = req_wdata;
                    d.wr      = req_write;
                    d.pid     = req_pid;
                    d.vway    = vic_way;
                    d.xl_have = xl_resp_valid;
                    d.pline   = xl_resp_paddr[PA_W-1:OFF_W];
                    if (hit) begin
                        d.rvalid  = 1'b1;
                        d.rdata   = req_write ? req_wdata
                                              : get_word(rd_line[hit_way], wsel_of(req_vaddr));
                        d.xl_pend = !xl_resp_valid;
                        lru_we    = 1'b1;
                        lru_set   = idx_of(req_vaddr);
                        lru_val   = (hit_way == '0);
                        if (req_write) begin
                            wr_en         = 1'b1;
                            wr_set        = idx_of(req_vaddr);
                            wr_way        = hit_way;
                            wr_meta       = hmeta;
                            wr_meta.dirty = 1'b1;
                            wr_line       = put_word(rd_line[hit_way], wsel_of(req_vaddr), req_wdata);
                        end
                    end else begin
                        d.st = ST_XL;
                    end
                end
            end

            ST_XL: begin
                if (q.xl_have) begin
                    d.st = (vmeta.valid && vmeta.dirty) ? ST_WB : ST_FILL;
                end else if (xl_resp_valid) begin
                    d.xl_have = 1'b1;
                    d.pline   = xl_resp_paddr[PA_W-1:OFF_W];
                end
            end

            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = vmeta.pline;
                mem_req_wline = rd_line[q.vway];
                if (mem_resp_valid) d.st = ST_FILL;
            end

            ST_FILL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = q.pline;
                if (mem_resp_valid) begin
                    wr_en         = 1'b1;
                    wr_meta.valid = 1'b1;
                    wr_meta.dirty = q.wr;
                    wr_meta.vtag  = vtag_of(q.va);
                    wr_meta.pid   = q.pid;
                    wr_meta.pline = q.pline;
                    wr_line       = q.wr ? put_word(mem_resp_rline, wsel_of(q.va), q.wdata)
                                         : mem_resp_rline;
                    lru_we        = 1'b1;
                    lru_val       = (q.vway == '0);
                    d.rvalid      = 1'b1;
                    d.rdata       = q.wr ? q.wdata : get_word(mem_resp_rline, wsel_of(q.va));
                    d.xl_have     = 1'b0;
                    d.st          = ST_IDLE;
                end
            end

            ST_FL_SCAN, ST_FL_WB: begin
                rd_set  = fset;
                wr_set  = fset;
                wr_way  = fway;
                wr_meta = '0;
                wr_line = rd_line[fway];
                if (q.st == ST_FL_SCAN && fmeta.valid && fmeta.dirty) begin
                    d.st = ST_FL_WB;
                end else begin
                    if (q.st == ST_FL_WB) begin
                        mem_req_valid = 1'b1;
                        mem_req_write = 1'b1;
                        mem_req_addr  = fmeta.pline;
                        mem_req_wline = rd_line[fway];
                    end
                    if (q.st == ST_FL_SCAN || mem_resp_valid) begin
                        wr_en = 1'b1;
                        if (q.fptr == LN_W'(LINES - 1)) begin
                            d.st    = ST_IDLE;
                            d.fdone = 1'b1;
                        end else begin
                            d.fptr = q.fptr + 1'b1;
                            d.st   = ST_FL_SCAN;
                        end
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vtc_cache_chk.sv
module vtc_cache_chk
    import vtc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic [PID_W-1:0]   req_pid,
    input logic               resp_valid,
    input logic               xl_req_valid,
    input logic [VA_W-1:0]    xl_req_vaddr,
    input logic [PID_W-1:0]   xl_req_pid,
    input logic               xl_resp_valid,
    input logic               mem_req_valid,
    input logic               mem_req_write,
    input logic [PLINE_W-1:0] mem_req_addr,
    input logic               mem_resp_valid,
    input logic               flush_done
);
    logic cpu_out_q;
    logic xl_out_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      cpu_out_q <= 1'b0;
        else if (req_valid && req_ready) cpu_out_q <= 1'b1;
        else if (resp_valid)             cpu_out_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             xl_out_q <= 1'b0;
        else if (xl_req_valid)  xl_out_q <= 1'b1;
        else if (xl_resp_valid) xl_out_q <= 1'b0;
    end

    a_r2_xl_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> xl_req_valid && xl_req_vaddr == req_vaddr && xl_req_pid == req_pid);

    a_r11_single_xl: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req_valid |-> !xl_out_q);

    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !cpu_out_q || resp_valid);

    a_r3_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> cpu_out_q);

    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);
endmodule

bind vtc_cache vtc_cache_chk u_chk (.*);

// File: tb/tb_vtc_cache.sv
module tb_vtc_cache;
    import vtc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NLINES     = 512;
    localparam int MEM_LAT    = 3;
    localparam logic [7:0] PA = 8'h11;
    localparam logic [7:0] PB = 8'h22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic [PID_W-1:0] req_pid = '0;
    logic resp_valid;
    logic [WORD_W-1:0] resp_rdata;
    logic xl_req_valid, xl_resp_valid;
    logic [VA_W-1:0] xl_req_vaddr;
    logic [PID_W-1:0] xl_req_pid;
    logic [PA_W-1:0] xl_resp_paddr;
    logic mem_req_valid, mem_req_write, mem_resp_valid;
    logic [PLINE_W-1:0] mem_req_addr;
    logic [LINE_W-1:0] mem_req_wline, mem_resp_rline;
    logic flush_req = 1'b0, flush_done;

    int checks = 0, errors = 0;
    int xl_lat = 3, xl_cnt, mem_cnt, wb_count = 0, hold_err = 0;
    logic [PA_W-1:0] xl_pa;
    logic [PLINE_W-1:0] mem_addr0;
    logic [LINE_W-1:0] pmem [NLINES];
    logic [LINE_W-1:0] gold [NLINES];

    always #(CLK_PERIOD/2) clk = ~clk;

    vtc_cache dut (.*);

    function automatic logic [8:0] pl_of(input logic [31:0] va, input logic [7:0] pid);
        return {pid[0], va[13:12], va[10:5]};
    endfunction

    function automatic logic [31:0] va_of(input int t, input int s, input int w);
        return 32'((t << 12) | (s << 5) | (w << 2));
    endfunction

    // translation model: answers after xl_lat cycles
    assign xl_resp_valid  = (xl_cnt == 1);
    assign xl_resp_paddr  = xl_pa;
    assign mem_resp_valid = (mem_cnt == 1);
    assign mem_resp_rline = pmem[mem_req_addr[8:0]];

    always @(posedge clk) begin
        if (!rst_n) begin
            xl_cnt  <= 0;
            mem_cnt <= 0;
        end else begin
            if (xl_req_valid) begin
                xl_cnt <= xl_lat;
                xl_pa  <= PA_W'(pl_of(xl_req_vaddr, xl_req_pid)) << OFF_W;
            end else if (xl_cnt != 0) xl_cnt <= xl_cnt - 1;
            if (mem_cnt == 0 && mem_req_valid && !mem_resp_valid) begin
                mem_cnt   <= MEM_LAT;
                mem_addr0 <= mem_req_addr;
            end else if (mem_cnt != 0) begin
                mem_cnt <= mem_cnt - 1;
                if (mem_req_addr != mem_addr0 || !mem_req_valid) hold_err++;
            end
            if (mem_resp_valid && mem_req_write) begin
                pmem[mem_req_addr[8:0]] <= mem_req_wline;
                wb_count++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic access(input bit wr, input logic [31:0] va, input logic [31:0] wd,
                          input logic [7:0] pid, output logic [31:0] rd, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd; req_pid = pid;
        #1;
        // R2: translation request leaves in the acceptance cycle
        chk(xl_req_valid && xl_req_vaddr == va && xl_req_pid == pid, "R2 xl request", xl_req_vaddr, va);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid) begin @(negedge clk); lat++; end
        rd = resp_rdata;
    endtask

    task automatic op(input bit wr, input logic [31:0] va, input logic [31:0] wd,
                      input logic [7:0] pid, input string tag, output int lat);
        logic [8:0] p;
        logic [31:0] exp, rd;
        p = pl_of(va, pid);
        exp = wr ? wd : gold[p][va[4:2]*32 +: 32];
        access(wr, va, wd, pid, rd, lat);
        if (wr) gold[p][va[4:2]*32 +: 32] = wd;
        chk(rd == exp, tag, rd, exp);
    endtask

    task automatic do_flush();
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        n = 0;
        while (!flush_done && n < 5000) begin @(negedge clk); n++; end
        chk(flush_done, "R9 flush_done raised", 32'(flush_done), 1);
        @(negedge clk);
        chk(!flush_done, "R9 flush_done one cycle", 32'(flush_done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat, wb0;
        logic [31:0] rd;
        for (int p = 0; p < NLINES; p++)
            for (int w = 0; w < WORDS; w++) begin
                pmem[p][w*32 +: 32] = 32'h5A00_0000 | 32'(p << 8) | 32'(w);
                gold[p][w*32 +: 32] = 32'h5A00_0000 | 32'(p << 8) | 32'(w);
            end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(req_ready, "R12 ready", 32'(req_ready), 1);
        chk(!resp_valid && !mem_req_valid && !flush_done, "R12 outputs low",
            32'({resp_valid, mem_req_valid, flush_done}), 0);

        // R1/R5: cold misses across sets, refill from translated line
        for (int s = 0; s < 64; s++) begin
            op(0, va_of(0, s, s % 8), 0, PA, "R5 miss refill data", lat);
            chk(lat > 1, "R5 cold miss latency", lat, 2);
        end
        // R3: hits answered next cycle even with slow translation
        xl_lat = 6;
        for (int s = 0; s < 64; s++) begin
            op(0, va_of(0, s, (s + 3) % 8), 0, PA, "R3 hit data", lat);
            chk(lat == 1, "R3 hit latency", lat, 1);
            if (s == 0) chk(!req_ready, "R11 ready low while translation pending", 32'(req_ready), 0);
        end
        // R7: store hits
        for (int s = 0; s < 64; s++) begin
            op(1, va_of(0, s, 1), 32'hC0DE_0000 + 32'(s), PA, "R7 store hit echo", lat);
            chk(lat == 1, "R7 store hit latency", lat, 1);
            op(0, va_of(0, s, 1), 0, PA, "R7 store hit readback", lat);
        end
        // R4/R10: same virtual address, other process
        xl_lat = 2;
        for (int s = 0; s < 16; s++) begin
            op(0, va_of(0, s, 1), 0, PB, "R4 other pid data", lat);
            chk(lat > 1, "R4 other pid misses", lat, 2);
            op(0, va_of(0, s, 1), 0, PA, "R10 first pid kept", lat);
            chk(lat == 1, "R10 first pid still hits", lat, 1);
        end
        // R1/R6/R7/R8: replacement and write-back
        for (int s = 0; s < 16; s++) begin
            op(0, va_of(1, s, 0), 0, PA, "R1 second tag data", lat);
            op(0, va_of(0, s, 1), 0, PA, "R8 mru kept", lat);
            chk(lat == 1, "R8 lru evicted other pid", lat, 1);
            op(0, va_of(0, s, 2), 0, PB, "R8 evicted pid refetch", lat);
            chk(lat > 1, "R8 evicted line misses", lat, 2);
            wb0 = wb_count;
            op(1, va_of(2, s, 5), 32'hBEEF_0000 + 32'(s), PA, "R7 store miss echo", lat);
            chk(lat > 1, "R7 store miss allocates", lat, 2);
            chk(wb_count == wb0 + 1, "R6 dirty victim written back", wb_count, wb0 + 1);
            rd = pmem[pl_of(va_of(0, s, 1), PA)][1*32 +: 32];
            chk(rd == 32'hC0DE_0000 + 32'(s), "R6 write-back physical line", rd, 32'hC0DE_0000 + 32'(s));
            op(0, va_of(0, s, 1), 0, PA, "R6 refetch after write-back", lat);
            op(0, va_of(2, s, 5), 0, PA, "R7 allocated line", lat);
            chk(lat == 1, "R7 allocated line hits", lat, 1);
        end
        // R9: flush writes back dirty lines and invalidates
        do_flush();
        for (int p = 0; p < NLINES; p++)
            chk(pmem[p] == gold[p], "R9 memory image after flush", pmem[p][31:0], gold[p][31:0]);
        for (int s = 0; s < 8; s++) begin
            op(0, va_of(2, s, 5), 0, PA, "R9 data after flush", lat);
            chk(lat > 1, "R9 line invalidated", lat, 2);
        end
        chk(hold_err == 0, "R13 memory request held", hold_err, 0);
        finish_run();
    end
endmodule